// File: doc/BRIEF.md
# Global Exclusive Access Monitor

This block sits on the request path between several initiators and a shared downstream target. It keeps a small reservation table in which each initiator may own at most one byte range. An exclusive read records a reservation. An exclusive write succeeds only if it hits that initiator's own reservation exactly. A plain write wipes out every reservation it touches, whoever owns it. The block decides per write whether the request may travel downstream. It reports exclusive pass or fail status, and it tells the initiator when it must not use a direct-access shortcut for the returned data.

One request is in flight at a time. A request is accepted when `req_valid` is high while `req_ready` is high. A forwarded request appears on the `fwd_*` outputs for one cycle, and the downstream side later pulses `dn_done` with an error flag. The upstream response follows on `rsp_*`. A failing exclusive write is answered without being forwarded. Creating a reservation pulses `inv_valid` with the reserved range, so that cached direct-access windows over that range can be dropped.

Top module: `excl_mon`

## Requirements
- R1: A reservation covers the bytes from the request address through address plus length minus 1, inclusive. When a reservation is created, `inv_valid` pulses in the same cycle as its response, with `inv_start` equal to the address and `inv_end` equal to address plus length minus 1.
- R2: A request hits a reservation when neither range ends before the other begins. A range ending one byte before a reservation's start, or starting one byte after its end, does not hit it.
- R3: An exclusive read that hits any reservation leaves the table unchanged and creates no new reservation.
- R4: An exclusive read that hits nothing first drops any reservation its initiator already holds, then reserves the read's own range.
- R5: An exclusive write fails in three cases: its initiator holds no reservation, the reservation it hits belongs to another initiator, or its start or end differs from the reservation's bounds. A failing write is not forwarded (`fwd_valid` stays 0). One cycle after acceptance it gets a response with `rsp_err`=1 and `rsp_xfail`=1.
- R6: A successful exclusive write is forwarded and drops its reservation. Its response carries `rsp_xpass`=1 and `rsp_xfail`=0.
- R7: A plain write drops every reservation that its range overlaps, whichever initiators own them, all in one cycle. It is then forwarded.
- R8: Read-side table changes happen only when the downstream side answers with `dn_err`=0. When `dn_err`=1 the table is unchanged and the response carries `rsp_err`=1.
- R9: `rsp_nodirect`=1 on the response to every exclusive read that downstream answers without error. It is also 1 on a plain read that hits a reservation. It is 0 on every write response and on every error response.
- R10: Reset is synchronous and active high. It empties the table and leaves `req_ready`=1 with `fwd_valid`, `rsp_valid` and `inv_valid` all 0.
- R11: A forwarded request appears on `fwd_*` one cycle after acceptance. `req_ready` stays 0 until the response, which comes one cycle after the `dn_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access |
| req_id | input | IDW | Initiator identifier |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte length, at least 1 |
| fwd_valid | output | 1 | One-cycle downstream request pulse |
| fwd_write | output | 1 | Forwarded command |
| fwd_id | output | IDW | Forwarded initiator identifier |
| fwd_addr | output | AW | Forwarded start address |
| fwd_len | output | LW | Forwarded byte length |
| dn_done | input | 1 | Downstream completion pulse |
| dn_err | input | 1 | Downstream reported an error |
| rsp_valid | output | 1 | Upstream response pulse |
| rsp_err | output | 1 | Error response |
| rsp_xpass | output | 1 | Exclusive write succeeded |
| rsp_xfail | output | 1 | Exclusive write failed |
| rsp_nodirect | output | 1 | Initiator must not use direct access for this range |
| inv_valid | output | 1 | New reservation created |
| inv_start | output | AW | First byte of new reservation |
| inv_end | output | AW | Last byte of new reservation |

## Verification
A failing exclusive write is answered on the cycle after acceptance, so the bench looks for `rsp_valid` at the first falling edge after the accepting rising edge. A forwarded request shows on `fwd_*` at that same falling edge. The bench then holds `dn_done` back for zero to two cycles, checking that `req_ready` stays low and that no response has come. The response and any invalidate pulse are due one cycle after `dn_done`, and the bench samples them at the next falling edge. Table state is never read directly. It is inferred from later exclusive writes and plain-read direct-access flags.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } mon_state_e;

  // Command class held while a request is downstream.
  typedef struct packed {
    logic wr;
    logic ex;
    logic xpass;
  } held_cmd_t;

endpackage

// File: rtl/excl_region_table.sv
module excl_region_table #(
  parameter int N_ID = 4,
  parameter int AW   = 32,
  localparam int IDW = (N_ID > 1) ? $clog2(N_ID) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   q_start,
  input  logic [AW-1:0]   q_end,
  input  logic [N_ID-1:0] clr_mask,
  input  logic            set_en,
  input  logic [IDW-1:0]  set_id,
  input  logic [AW-1:0]   set_start,
  input  logic [AW-1:0]   set_end,
  output logic [N_ID-1:0] hit_vec,
  output logic [N_ID-1:0] exact_vec
);

  logic [N_ID-1:0] vld_q;
  logic [AW-1:0]   st_q [N_ID];
  logic [AW-1:0]   en_q [N_ID];

  for (genvar g = 0; g < N_ID; g++) begin : g_ent
    logic set_here;
    assign set_here = set_en && (set_id == IDW'(g));

    // Overlap test: neither range ends before the other begins.
    assign hit_vec[g]   = vld_q[g] && !(en_q[g] < q_start) && !(st_q[g] > q_end);
    assign exact_vec[g] = vld_q[g] && (st_q[g] == q_start) && (en_q[g] == q_end);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
        st_q[g]  <= '0;
        en_q[g]  <= '0;
      end else if (set_here) begin
        vld_q[g] <= 1'b1;
        st_q[g]  <= set_start;
        en_q[g]  <= set_end;
      end else if (clr_mask[g]) begin
        vld_q[g] <= 1'b0;
      end
    end

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_mask[g] && !set_here) |=> !vld_q[g]);
  end

  // R4
  region_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> vld_q[$past(set_id)]);

endmodule

// File: rtl/excl_write_judge.sv
module excl_write_judge #(
  parameter int N_ID = 4,
  localparam int IDW = (N_ID > 1) ? $clog2(N_ID) : 1
) (
  input  logic [N_ID-1:0] hit_vec,
  input  logic [N_ID-1:0] exact_vec,
  input  logic [IDW-1:0]  req_id,
  input  logic            req_excl,
  output logic            any_hit,
  output logic            excl_ok,
  output logic [N_ID-1:0] wr_clr
);

  logic [N_ID-1:0] own_mask;

  always_comb begin
    own_mask         = '0;
    own_mask[req_id] = 1'b1;
  end

  // Held reservations never overlap each other. So an exact hit on the
  // requester's own entry means no other entry can be hit.
  assign any_hit = |hit_vec;
  assign excl_ok = |(exact_vec & own_mask);
  assign wr_clr  = req_excl ? own_mask : hit_vec;

endmodule

// File: rtl/excl_mon.sv
module excl_mon
  import excl_mon_pkg::*;
#(
  parameter int N_ID = 4,
  parameter int AW   = 32,
  parameter int LW   = 8,
  localparam int IDW = (N_ID > 1) ? $clog2(N_ID) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_excl,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic [LW-1:0]  req_len,
  output logic           fwd_valid,
  output logic           fwd_write,
  output logic [IDW-1:0] fwd_id,
  output logic [AW-1:0]  fwd_addr,
  output logic [LW-1:0]  fwd_len,
  input  logic           dn_done,
  input  logic           dn_err,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic           rsp_xpass,
  output logic           rsp_xfail,
  output logic           rsp_nodirect,
  output logic           inv_valid,
  output logic [AW-1:0]  inv_start,
  output logic [AW-1:0]  inv_end
);

  mon_state_e      state_q;
  held_cmd_t       h_cmd_q;
  logic [IDW-1:0]  h_id_q;
  logic [AW-1:0]   h_start_q, h_end_q;

  logic [AW-1:0]   req_end, q_start, q_end;
  logic [N_ID-1:0] hit_vec, exact_vec, wr_clr, clr_mask;
  logic [IDW-1:0]  q_id;
  logic            q_excl, any_hit, excl_ok;
  logic            accept, wr_now, excl_fail, done, set_en, nodirect_nx;

  assign req_end = req_addr + AW'(req_len) - AW'(1);
  assign req_ready = (state_q == ST_IDLE);

  // Lookup key: the incoming request while idle, the held one while waiting.
  assign q_start = req_ready ? req_addr  : h_start_q;
  assign q_end   = req_ready ? req_end   : h_end_q;
  assign q_id    = req_ready ? req_id    : h_id_q;
  assign q_excl  = req_ready ? req_excl  : h_cmd_q.ex;

  excl_region_table #(.N_ID(N_ID), .AW(AW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .q_start   (q_start),
    .q_end     (q_end),
    .clr_mask  (clr_mask),
    .set_en    (set_en),
    .set_id    (h_id_q),
    .set_start (h_start_q),
    .set_end   (h_end_q),
    .hit_vec   (hit_vec),
    .exact_vec (exact_vec)
  );

  excl_write_judge #(.N_ID(N_ID)) u_judge (
    .hit_vec   (hit_vec),
    .exact_vec (exact_vec),
    .req_id    (q_id),
    .req_excl  (q_excl),
    .any_hit   (any_hit),
    .excl_ok   (excl_ok),
    .wr_clr    (wr_clr)
  );

  assign accept    = req_ready && req_valid;
  assign wr_now    = accept && req_write;
  assign excl_fail = wr_now && req_excl && !excl_ok;
  assign clr_mask  = (wr_now && !excl_fail) ? wr_clr : '0;

  assign done        = (state_q == ST_WAIT) && dn_done;
  assign set_en      = done && !h_cmd_q.wr && h_cmd_q.ex && !dn_err && !any_hit;
  assign nodirect_nx = !h_cmd_q.wr && !dn_err && (h_cmd_q.ex || any_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      h_cmd_q      <= '0;
      h_id_q       <= '0;
      h_start_q    <= '0;
      h_end_q      <= '0;
      fwd_valid    <= 1'b0;
      fwd_write    <= 1'b0;
      fwd_id       <= '0;
      fwd_addr     <= '0;
      fwd_len      <= '0;
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_xpass    <= 1'b0;
      rsp_xfail    <= 1'b0;
      rsp_nodirect <= 1'b0;
      inv_valid    <= 1'b0;
      inv_start    <= '0;
      inv_end      <= '0;
    end else begin
      fwd_valid <= 1'b0;
      rsp_valid <= 1'b0;
      inv_valid <= 1'b0;
      if (accept) begin
        if (excl_fail) begin
          rsp_valid    <= 1'b1;
          rsp_err      <= 1'b1;
          rsp_xpass    <= 1'b0;
          rsp_xfail    <= 1'b1;
          rsp_nodirect <= 1'b0;
        end else begin
          fwd_valid     <= 1'b1;
          fwd_write     <= req_write;
          fwd_id        <= req_id;
          fwd_addr      <= req_addr;
          fwd_len       <= req_len;
          h_cmd_q.wr    <= req_write;
          h_cmd_q.ex    <= req_excl;
          h_cmd_q.xpass <= req_write && req_excl;
          h_id_q        <= req_id;
          h_start_q     <= req_addr;
          h_end_q       <= req_end;
          state_q       <= ST_WAIT;
        end
      end
      if (done) begin
        rsp_valid    <= 1'b1;
        rsp_err      <= dn_err;
        rsp_xpass    <= h_cmd_q.xpass;
        rsp_xfail    <= 1'b0;
        rsp_nodirect <= nodirect_nx;
        inv_valid    <= set_en;
        inv_start    <= h_start_q;
        inv_end      <= h_end_q;
        state_q      <= ST_IDLE;
      end
    end
  end

  // R5
  xfail_drop_chk: assert property (@(posedge clk) disable iff (rst)
    excl_fail |=> (rsp_valid && rsp_err && rsp_xfail && !fwd_valid));

  // R6
  xstatus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_xpass && rsp_xfail));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !req_ready);

  // R1
  inv_resp_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (rsp_valid && !rsp_err && (inv_start <= inv_end)));

  // R9
  nodirect_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !rsp_nodirect);

  // R11
  fwd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> !fwd_valid);

endmodule

// File: tb/excl_mon_bench.sv
`timescale 1ns/1ps
module excl_mon_bench;

  localparam int N_ID = 4;
  localparam int AW   = 16;
  localparam int LW   = 8;
  localparam int IDW  = 2;

  typedef struct packed {
    logic        wr;
    logic        ex;
    logic [1:0]  id;
    logic [15:0] addr;
    logic [7:0]  len;
    logic        derr;
    logic        efwd;
    logic        eerr;
    logic        expass;
    logic        exfail;
    logic        enod;
    logic        einv;
  } vec_t;

  localparam int NV = 23;
  // fields: wr ex id addr len derr | fwd err xpass xfail nodirect inv
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,2'd0,16'h0100,8'd8, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4 id0 reserves 100..107
    '{1'b0,1'b1,2'd1,16'h0104,8'd4, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 overlap, no change
    '{1'b1,1'b1,2'd1,16'h0104,8'd4, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R5 other owner
    '{1'b0,1'b0,2'd0,16'h0106,8'd1, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2 inside
    '{1'b0,1'b0,2'd2,16'h0108,8'd4, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 one past end
    '{1'b1,1'b1,2'd0,16'h0100,8'd4, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R5 not exact
    '{1'b1,1'b1,2'd0,16'h0100,8'd8, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 pass
    '{1'b1,1'b1,2'd0,16'h0100,8'd8, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R6 released -> fail
    '{1'b0,1'b1,2'd1,16'h0200,8'd4, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4 id1 200..203
    '{1'b0,1'b1,2'd1,16'h0300,8'd2, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4 id1 moves to 300..301
    '{1'b0,1'b1,2'd2,16'h0200,8'd4, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4 old id1 range free
    '{1'b0,1'b0,2'd0,16'h01FC,8'd4, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 ends just before
    '{1'b0,1'b0,2'd0,16'h01FC,8'd5, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2 touches start
    '{1'b0,1'b1,2'd3,16'h0210,8'd16,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R1 id3 210..21F
    '{1'b1,1'b0,2'd0,16'h01FC,8'h20,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R7 clears id2 and id3
    '{1'b1,1'b1,2'd2,16'h0200,8'd4, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R7 id2 gone
    '{1'b1,1'b1,2'd3,16'h0210,8'd16,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R7 id3 gone
    '{1'b0,1'b1,2'd3,16'h0400,8'd4, 1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 downstream error
    '{1'b1,1'b1,2'd3,16'h0400,8'd4, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R8 nothing recorded
    '{1'b0,1'b0,2'd1,16'h0301,8'd1, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R9 id1 region survived
    '{1'b1,1'b1,2'd2,16'h0300,8'd2, 1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R5 wrong owner
    '{1'b1,1'b1,2'd1,16'h0300,8'd2, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 owner pass
    '{1'b0,1'b0,2'd1,16'h0300,8'd2, 1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}  // R9 nothing left
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_write = 1'b0;
  logic           req_excl = 1'b0;
  logic [IDW-1:0] req_id = '0;
  logic [AW-1:0]  req_addr = '0;
  logic [LW-1:0]  req_len = '0;
  logic           fwd_valid, fwd_write;
  logic [IDW-1:0] fwd_id;
  logic [AW-1:0]  fwd_addr;
  logic [LW-1:0]  fwd_len;
  logic           dn_done = 1'b0;
  logic           dn_err = 1'b0;
  logic           rsp_valid, rsp_err, rsp_xpass, rsp_xfail, rsp_nodirect;
  logic           inv_valid;
  logic [AW-1:0]  inv_start, inv_end;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  excl_mon #(.N_ID(N_ID), .AW(AW), .LW(LW)) u_excl_mon (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr), .req_len(req_len),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_id(fwd_id),
    .fwd_addr(fwd_addr), .fwd_len(fwd_len),
    .dn_done(dn_done), .dn_err(dn_err),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_xpass(rsp_xpass),
    .rsp_xfail(rsp_xfail), .rsp_nodirect(rsp_nodirect),
    .inv_valid(inv_valid), .inv_start(inv_start), .inv_end(inv_end)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int dly, input int idx);
    logic [AW-1:0] e_end;
    e_end = v.addr + AW'(v.len) - AW'(1);
    @(negedge clk);
    chk("R11", $sformatf("v%0d ready before", idx), 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = v.wr; req_excl = v.ex;
    req_id = v.id; req_addr = v.addr; req_len = v.len;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5", $sformatf("v%0d forwarded", idx), 32'(fwd_valid), 32'(v.efwd));
    if (v.efwd) begin
      // R11 forwarded fields one cycle after acceptance
      chk("R11", $sformatf("v%0d fwd addr", idx), 32'(fwd_addr), 32'(v.addr));
      chk("R11", $sformatf("v%0d fwd len/id/cmd", idx),
          {21'd0, fwd_write, fwd_id, fwd_len}, {21'd0, v.wr, v.id, v.len});
      chk("R11", $sformatf("v%0d no early rsp", idx), 32'(rsp_valid), 32'd0);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk("R11", $sformatf("v%0d busy", idx), {30'd0, req_ready, rsp_valid}, 32'd0);
      end
      dn_done = 1'b1; dn_err = v.derr;
      @(negedge clk);
      dn_done = 1'b0; dn_err = 1'b0;
    end
    chk("R11", $sformatf("v%0d rsp valid", idx), 32'(rsp_valid), 32'd1);
    chk("R8", $sformatf("v%0d rsp err", idx), 32'(rsp_err), 32'(v.eerr));
    chk("R6", $sformatf("v%0d xpass", idx), 32'(rsp_xpass), 32'(v.expass));
    chk("R5", $sformatf("v%0d xfail", idx), 32'(rsp_xfail), 32'(v.exfail));
    chk("R9", $sformatf("v%0d nodirect", idx), 32'(rsp_nodirect), 32'(v.enod));
    chk("R1", $sformatf("v%0d inv pulse", idx), 32'(inv_valid), 32'(v.einv));
    if (v.einv) begin
      chk("R1", $sformatf("v%0d inv start", idx), 32'(inv_start), 32'(v.addr));
      chk("R1", $sformatf("v%0d inv end", idx), 32'(inv_end), 32'(e_end));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 idle state after reset
    chk("R10", "ready after reset", 32'(req_ready), 32'd1);
    chk("R10", "outputs idle after reset", {29'd0, fwd_valid, rsp_valid, inv_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i % 3, i);

    // R10 reset empties the table: reserve, reset, then exclusive write fails
    run_vec('{1'b0,1'b1,2'd0,16'h0500,8'd4,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, 1, 100);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R10", "ready after mid reset", 32'(req_ready), 32'd1);
    run_vec('{1'b1,1'b1,2'd0,16'h0500,8'd4,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, 0, 101);

    // R10 reset during an outstanding request returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_excl = 1'b0; req_addr = 16'h0600; req_len = 8'd2;
    @(negedge clk); req_valid = 1'b0;
    chk("R11", "busy while outstanding", 32'(req_ready), 32'd0);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10", "reset clears busy", {30'd0, req_ready, rsp_valid}, 32'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule